// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a tree of translation tables held in memory. The walk starts in a per-context root table, whose slot is picked by the context number. It then descends through at most three further tables, using successive virtual-address fields as indices. A leaf entry can appear at any of the three lower levels, so one leaf maps a 16 MB, a 256 KB or a 4 KB region. All table traffic uses a single-word memory port. After a successful walk the block marks the leaf as referenced, and also as modified when the request is a write. It writes the entry back only when one of those two marks actually changes. A walk that fails returns a packed code giving the level and the kind of failure.

Requests use a valid/ready handshake. `req_ready` is high only while the walker is idle, so it takes one request at a time. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The result comes back as a single-cycle `rsp_valid` pulse. The response has no back-pressure, so the consumer must capture it in that cycle.

The memory request side also uses valid/ready. The walker holds address, data and direction steady until `mem_req_ready` is seen. A read returns its data as a one-cycle `mem_rsp_valid` at a later edge. A write gets no response. When translation is switched off, the address passes straight through and no memory traffic occurs.

Top module: `pgwalk_top`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is accepted when `req_valid` and `req_ready` are high together, and no second request is taken until the response has been given.
- R2: The first memory read of an enabled walk goes to address `(cfg_root_ptr << 4) + (cfg_context << 2)`.
- R3: Bits 1:0 of every fetched entry give its type: 0 invalid, 1 table pointer, 2 leaf, 3 reserved. A pointer leads to address `({entry[31:2],2'b00} << 4) + index`. The index is `va[31:24]*4` when leaving the root entry, `va[23:18]*4` when leaving a first-level entry, and `va[17:12]*4` when leaving a second-level entry.
- R4: A leaf at level 1, 2 or 3 gives `paddr = ({entry[31:8]} << 12) + offset`. The offset is `va[23:0]`, `va[17:0]` or `va[11:0]` respectively.
- R5: On failure `rsp_fault` is 1 and `rsp_err` bits 9:8 hold the failing level (root = 0). Bits 4:2 hold 1 for an invalid entry and 4 for a reserved or misplaced type. All other bits of `rsp_err` are 0.
- R6: In the root entry a pointer continues the walk. An invalid root entry gives code 0x004, and a leaf or reserved root entry gives code 0x010.
- R7: A pointer found in a third-level entry is a failure with code 0x310.
- R8: After a successful walk the returned entry has bit 5 (referenced) set, and on a write also bit 6 (modified). The entry is written back to its own address only if this changed it; otherwise no write occurs.
- R9: With `cfg_enable` low, `paddr` is the zero-extended virtual address and `rsp_bypass` is 1. `rsp_valid` rises in the cycle after acceptance, and no memory request is made.
- R10: `rsp_valid` is high for exactly one cycle per request. It carries back the request's write, fetch and supervisor flags.
- R11: Once `mem_req_valid` is raised, it stays high with a stable address, data and direction until `mem_req_ready` is sampled high. A failed walk makes no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Translation on when high |
| cfg_root_ptr | input | PA_W-4 | Root table pointer (address >> 4) |
| cfg_context | input | CTX_W | Current context number |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_super | input | 1 | Access is in supervisor mode |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Walk failed |
| rsp_bypass | output | 1 | Translation was off |
| rsp_err | output | 10 | Packed failure code |
| rsp_paddr | output | PA_W | Physical address |
| rsp_entry | output | 32 | Leaf entry after marking |
| rsp_write | output | 1 | Echo of request write flag |
| rsp_fetch | output | 1 | Echo of request fetch flag |
| rsp_super | output | 1 | Echo of request supervisor flag |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | PA_W | Memory byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The assertions assume a well-behaved memory. It raises `mem_rsp_valid` exactly once for each accepted read, only while a read is outstanding, and never for a write. They also assume that `cfg_*` stays steady during a walk. The bench memory model keeps to this: it answers each read on the falling edge after the handshake with a single-cycle strobe, and it leaves configuration alone except between requests. One walk stretches the handshake by toggling `mem_req_ready` every cycle, so the hold-steady rule on the memory request gets exercised.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int unsigned VA_W    = 32;
  localparam int unsigned ENT_W   = 32;
  localparam int unsigned ERR_W   = 10;
  localparam int unsigned REF_BIT = 5;
  localparam int unsigned MOD_BIT = 6;

  localparam logic [1:0] ET_INVALID = 2'd0;
  localparam logic [1:0] ET_PTR     = 2'd1;
  localparam logic [1:0] ET_LEAF    = 2'd2;
  localparam logic [1:0] ET_RSVD    = 2'd3;

  localparam logic [2:0] FC_INVALID = 3'd1;
  localparam logic [2:0] FC_BADTYPE = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT, ST_UPDATE, ST_DONE
  } walk_state_e;
endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
  parameter int unsigned PA_W = 36
) (
  input  logic [1:0]      level,
  input  logic [31:0]     vaddr,
  input  logic [29:0]     ptr_field,
  input  logic [23:0]     ppn_field,
  output logic [PA_W-1:0] next_addr,
  output logic [PA_W-1:0] leaf_paddr
);
  localparam int unsigned PAD_W = PA_W - 32;

  logic [9:0]  idx;
  logic [23:0] offset;

  // index into the table the pointer leads to, chosen by the current level
  always_comb begin
    unique case (level)
      2'd0:    idx = {vaddr[31:24], 2'b00};
      2'd1:    idx = {2'b00, vaddr[23:18], 2'b00};
      default: idx = {2'b00, vaddr[17:12], 2'b00};
    endcase
  end

  // region offset kept from the virtual address, by the level of the leaf
  always_comb begin
    unique case (level)
      2'd1:    offset = vaddr[23:0];
      2'd2:    offset = {6'd0, vaddr[17:0]};
      default: offset = {12'd0, vaddr[11:0]};
    endcase
  end

  assign next_addr  = ({{PAD_W{1'b0}}, ptr_field, 2'b00} << 4) + PA_W'(idx);
  assign leaf_paddr = PA_W'({ppn_field, 12'h000}) + PA_W'(offset);
endmodule

// File: rtl/pgw_ref_update.sv
module pgw_ref_update
  import pgw_pkg::*;
(
  input  logic [ENT_W-1:0] entry_in,
  input  logic             is_write,
  output logic [ENT_W-1:0] entry_out,
  output logic             changed
);
  logic [ENT_W-1:0] set_mask;

  always_comb begin
    set_mask          = '0;
    set_mask[REF_BIT] = 1'b1;
    set_mask[MOD_BIT] = is_write;
  end

  assign entry_out = entry_in | set_mask;
  assign changed   = (entry_in & set_mask) != set_mask;
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgw_pkg::*;
#(
  parameter int unsigned CTX_W = 8,
  parameter int unsigned PA_W  = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [PA_W-5:0]   cfg_root_ptr,
  input  logic [CTX_W-1:0]  cfg_context,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_vaddr,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              req_super,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_bypass,
  output logic [9:0]        rsp_err,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [31:0]       rsp_entry,
  output logic              rsp_write,
  output logic              rsp_fetch,
  output logic              rsp_super,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [PA_W-1:0]   mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata
);
  walk_state_e       state;
  logic [1:0]        level;
  logic [31:0]       va_q;
  logic [PA_W-1:0]   cur_addr;
  logic [PA_W-1:0]   root_slot;
  logic [PA_W-1:0]   next_addr;
  logic [PA_W-1:0]   leaf_paddr;
  logic [31:0]       marked_entry;
  logic              marks_changed;
  logic [1:0]        etype;
  logic              fail_now;
  logic [2:0]        fail_code;

  assign root_slot = PA_W'({cfg_root_ptr, 4'b0000}) + PA_W'({cfg_context, 2'b00});
  assign etype     = mem_rsp_rdata[1:0];

  pgw_addr_gen #(.PA_W(PA_W)) u_addr (
    .level      (level),
    .vaddr      (va_q),
    .ptr_field  (mem_rsp_rdata[31:2]),
    .ppn_field  (mem_rsp_rdata[31:8]),
    .next_addr  (next_addr),
    .leaf_paddr (leaf_paddr)
  );

  pgw_ref_update u_mark (
    .entry_in  (mem_rsp_rdata),
    .is_write  (rsp_write),
    .entry_out (marked_entry),
    .changed   (marks_changed)
  );

  // classify the fetched entry against the level it was found at
  always_comb begin
    fail_now  = 1'b0;
    fail_code = FC_INVALID;
    unique case (etype)
      ET_INVALID: fail_now = 1'b1;
      ET_PTR:     if (level == 2'd3) begin fail_now = 1'b1; fail_code = FC_BADTYPE; end
      ET_LEAF:    if (level == 2'd0) begin fail_now = 1'b1; fail_code = FC_BADTYPE; end
      default:    begin fail_now = 1'b1; fail_code = FC_BADTYPE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      level      <= '0;
      va_q       <= '0;
      cur_addr   <= '0;
      rsp_fault  <= 1'b0;
      rsp_bypass <= 1'b0;
      rsp_err    <= '0;
      rsp_paddr  <= '0;
      rsp_entry  <= '0;
      rsp_write  <= 1'b0;
      rsp_fetch  <= 1'b0;
      rsp_super  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          va_q       <= req_vaddr;
          rsp_write  <= req_write;
          rsp_fetch  <= req_fetch;
          rsp_super  <= req_super;
          rsp_fault  <= 1'b0;
          rsp_err    <= '0;
          rsp_entry  <= '0;
          level      <= 2'd0;
          if (!cfg_enable) begin
            rsp_bypass <= 1'b1;
            rsp_paddr  <= PA_W'(req_vaddr);
            state      <= ST_DONE;
          end else begin
            rsp_bypass <= 1'b0;
            rsp_paddr  <= '0;
            cur_addr   <= root_slot;
            state      <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (fail_now) begin
            rsp_fault <= 1'b1;
            rsp_err   <= {level, 3'b000, fail_code, 2'b00};
            state     <= ST_DONE;
          end else if (etype == ET_PTR) begin
            cur_addr <= next_addr;
            level    <= level + 2'd1;
            state    <= ST_FETCH;
          end else begin
            rsp_entry <= marked_entry;
            rsp_paddr <= leaf_paddr;
            state     <= marks_changed ? ST_UPDATE : ST_DONE;
          end
        end
        ST_UPDATE: if (mem_req_ready) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_DONE);
  assign mem_req_valid = (state == ST_FETCH) || (state == ST_UPDATE);
  assign mem_req_write = (state == ST_UPDATE);
  assign mem_req_addr  = cur_addr;
  assign mem_req_wdata = rsp_entry;

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r1_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r9_bypass_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_enable) |=> (rsp_valid && rsp_bypass && !mem_req_valid));
  a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));
  a_r5_err_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |->
      ((rsp_err[4:2] == FC_INVALID || rsp_err[4:2] == FC_BADTYPE) && rsp_err[7:5] == 3'b000 && rsp_err[1:0] == 2'b00));
  a_r8_writeback_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (mem_req_wdata[REF_BIT] && !rsp_fault));
  a_r8_write_sets_mod: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault && !rsp_bypass && rsp_write) |-> rsp_entry[MOD_BIT]);
endmodule

// File: tb/tb_pgwalk_top.sv
module tb_pgwalk_top;
  localparam int PA_W = 36;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_enable; logic [PA_W-5:0] cfg_root_ptr; logic [7:0] cfg_context;
  logic req_valid, req_ready, req_write, req_fetch, req_super; logic [31:0] req_vaddr;
  logic rsp_valid, rsp_fault, rsp_bypass, rsp_write, rsp_fetch, rsp_super;
  logic [9:0] rsp_err; logic [PA_W-1:0] rsp_paddr; logic [31:0] rsp_entry;
  logic mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
  logic [PA_W-1:0] mem_req_addr; logic [31:0] mem_req_wdata, mem_rsp_rdata;

  pgwalk_top dut (.*);

  logic [31:0] mem [logic [35:0]];
  int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0;
  bit stall = 0, tick = 0, pend = 0;
  logic [35:0] pend_addr;

  // memory model: acts on falling edges
  initial begin
    mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
        pend = 0;
      end
      tick = ~tick;
      mem_req_ready = stall ? tick : 1'b1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin mem[mem_req_addr] = mem_req_wdata; n_wr++; end
        else begin pend = 1; pend_addr = mem_req_addr; n_rd++; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  function automatic logic [31:0] ptr_to(input logic [35:0] a);
    return {a[35:6], 2'b01};
  endfunction
  function automatic logic [35:0] slot(input logic [35:0] base, input int lvl, input logic [31:0] va);
    case (lvl)
      1: return base + 36'(va[31:24]) * 4;
      2: return base + 36'(va[23:18]) * 4;
      default: return base + 36'(va[17:12]) * 4;
    endcase
  endfunction

  localparam logic [35:0] ROOT = 36'h1000;
  localparam logic [35:0] CTXA = 36'h100C;

  int lat;
  task automatic walk(input logic [31:0] va, input bit wr, input bit fe, input bit su);
    @(negedge clk);
    n_rd = 0; n_wr = 0;
    req_valid = 1; req_vaddr = va; req_write = wr; req_fetch = fe; req_super = su;
    @(negedge clk);
    req_valid = 0;
    lat = 0;
    while (!rsp_valid && lat < 200) begin @(negedge clk); lat++; end
  endtask

  task automatic after_rsp();
    @(negedge clk);
    chk(!rsp_valid, "R10 pulse one cycle", rsp_valid, 0);
    chk(req_ready, "R1 ready after response", req_ready, 1);
  endtask

  task automatic t_reset();
    chk(req_ready == 1 && rsp_valid == 0 && mem_req_valid == 0, "R1 reset state",
        {req_ready, rsp_valid, mem_req_valid}, 3'b100);
  endtask

  task automatic t_bypass();
    mem.delete(); cfg_enable = 0;
    walk(32'h1234_5678, 1, 0, 1);
    chk(lat == 0, "R9 latency", lat, 0);
    chk(rsp_paddr == 36'h0_1234_5678 && rsp_bypass && !rsp_fault, "R9 passthrough",
        rsp_paddr, 36'h012345678);
    chk(n_rd == 0 && n_wr == 0, "R9 no memory", n_rd + n_wr, 0);
    chk(rsp_write && !rsp_fetch && rsp_super, "R10 echo flags", {rsp_write, rsp_fetch, rsp_super}, 3'b101);
    after_rsp();
    cfg_enable = 1;
  endtask

  task automatic t_4k();
    logic [31:0] va = 32'h1234_5678;
    logic [35:0] a1, a2, a3;
    mem.delete(); stall = 1;
    a1 = slot(36'h2000, 1, va); a2 = slot(36'h3000, 2, va); a3 = slot(36'h4000, 3, va);
    mem[CTXA] = ptr_to(36'h2000); mem[a1] = ptr_to(36'h3000);
    mem[a2] = ptr_to(36'h4000); mem[a3] = 32'hABCD_E00E;
    walk(va, 0, 1, 0);
    chk(mem.num() == 4 && n_rd == 4, "R2 R3 four reads reach the set slots", n_rd, 4);
    chk(rsp_paddr == 36'hABCDE0678 && !rsp_fault, "R4 4KB paddr", rsp_paddr, 36'hABCDE0678);
    chk(rsp_entry == 32'hABCD_E02E, "R8 ref mark", rsp_entry, 32'hABCDE02E);
    chk(n_wr == 1 && mem[a3] == 32'hABCD_E02E, "R8 write-back", mem[a3], 32'hABCDE02E);
    chk(!rsp_write && rsp_fetch && !rsp_super, "R10 echo flags", {rsp_write, rsp_fetch, rsp_super}, 3'b010);
    after_rsp();
    stall = 0;
  endtask

  task automatic t_16m();
    logic [31:0] va = 32'h5ABC_DEF0;
    mem.delete();
    mem[CTXA] = ptr_to(36'h2000); mem[slot(36'h2000, 1, va)] = 32'h1230_0022;
    walk(va, 1, 0, 1);
    chk(rsp_paddr == 36'h123000000 + 36'hBCDEF0, "R4 16MB paddr", rsp_paddr, 36'h123BCDEF0);
    chk(rsp_entry == 32'h1230_0062 && n_wr == 1, "R8 modified mark on write", rsp_entry, 32'h12300062);
    chk(mem[slot(36'h2000, 1, va)] == 32'h1230_0062, "R8 stored entry", mem[slot(36'h2000, 1, va)], 32'h12300062);
    after_rsp();
  endtask

  task automatic t_256k();
    logic [31:0] va = 32'h00FF_3ABC;
    mem.delete();
    mem[CTXA] = ptr_to(36'h2000); mem[slot(36'h2000, 1, va)] = ptr_to(36'h3000);
    mem[slot(36'h3000, 2, va)] = 32'h0F0F_0F6E;
    walk(va, 1, 0, 0);
    chk(rsp_paddr == 36'h0F0F0F000 + 36'h33ABC, "R4 256KB paddr", rsp_paddr, 36'h0F0F0F000 + 36'h33ABC);
    chk(n_wr == 0 && rsp_entry == 32'h0F0F_0F6E, "R8 no write when unchanged", n_wr, 0);
    after_rsp();
  endtask

  task automatic t_fault(input string tag, input logic [31:0] root_e, input int depth,
                         input logic [31:0] last_e, input logic [9:0] exp_err);
    logic [31:0] va = 32'hC0DE_F123;
    mem.delete();
    if (depth == 0) mem[CTXA] = root_e;
    else begin
      mem[CTXA] = ptr_to(36'h2000);
      if (depth == 1) mem[slot(36'h2000, 1, va)] = last_e;
      else begin
        mem[slot(36'h2000, 1, va)] = ptr_to(36'h3000);
        if (depth == 2) mem[slot(36'h3000, 2, va)] = last_e;
        else begin
          mem[slot(36'h3000, 2, va)] = ptr_to(36'h4000);
          mem[slot(36'h4000, 3, va)] = last_e;
        end
      end
    end
    walk(va, 1, 0, 0);
    chk(rsp_fault && rsp_err == exp_err, tag, rsp_err, exp_err);
    chk(n_wr == 0 && n_rd == depth + 1, {tag, " R11 no write on fault"}, n_wr, 0);
    after_rsp();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cfg_enable = 1; cfg_root_ptr = 32'(ROOT >> 4); cfg_context = 8'd3;
    req_valid = 0; req_vaddr = 0; req_write = 0; req_fetch = 0; req_super = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_4k();
    t_16m();
    t_256k();
    t_fault("R6 root invalid", 32'h0, 0, 32'h0, 10'h004);
    t_fault("R6 root leaf", 32'h0000_0102, 0, 32'h0, 10'h010);
    t_fault("R5 level1 reserved", 32'h0, 1, 32'h0000_0013, 10'h110);
    t_fault("R5 level2 invalid", 32'h0, 2, 32'h0000_0000, 10'h204);
    t_fault("R7 level3 pointer", 32'h0, 3, 32'h0000_0501, 10'h310);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule